// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between ten interrupt request lines and a processor core. Each line has a fixed vector address, an enable bit and a level-select bit. The first two vectors can be raised to a top level that the other eight cannot reach. The other eight can be raised to a middle level. With its select bit clear, any vector sits at the bottom level. When the core signals that it can take an interrupt, the block chooses the winner among the eligible requests. It puts that vector's address on a registered output and pulses an acknowledge for one cycle.

The block keeps track of nested handlers. It holds one in-service flag per level. Accepting an interrupt sets the flag for the winner's level. A return strobe from the core clears the most recently entered level, which is the highest flag that is set. A request is eligible only while its level is strictly above the level of the innermost running handler. A request at that level or below waits until enough returns have been made.

Request flags belong to their sources. The arbiter never clears them. A source is expected to drop its request once the handler has serviced it.

Top module: `irq_nest_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `ack_o` is 0 and `vec_o` is 00h. No level is in service, so a bottom-level request is accepted as soon as `cpu_rdy_i` is high.
- R2: Vector k (k = 1..10, bit k-1 of each request, enable and select bus) has the address 03h + 8*(k-1), giving 03h, 0Bh, ... 4Bh. `vec_o` carries that address for an accepted vector k.
- R3: For vectors 1 and 2, select bit 1 gives the top level and 0 gives the bottom level. For vectors 3 to 10, select bit 1 gives the middle level and 0 gives the bottom level. Vectors 3 to 10 never reach the top level.
- R4: A request whose enable bit is 0 is never accepted.
- R5: Among eligible requests in the same cycle, the one at the higher level is accepted.
- R6: Among eligible requests at the same level, the vector with the lowest address is accepted.
- R7: A request at a level equal to or below the innermost in-service level is held off, whatever its enable. It is accepted only after returns have lowered the in-service level below its own level.
- R8: A request at a level strictly above the current in-service level is accepted while a handler is running. Its level becomes the new innermost level.
- R9: A cycle with `reti_i` high clears the highest in-service level that is set. With nothing in service, `reti_i` changes nothing.
- R10: An acceptance takes place only in a cycle with `cpu_rdy_i` high and `reti_i` low that does not directly follow an acknowledge. `ack_o` rises in the next cycle and lasts exactly one cycle.
- R11: `vec_o` changes only when a new acknowledge is issued and holds its last value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | 10 | Request line per vector, bit k-1 for vector k |
| irq_en_i | input | 10 | Enable per vector |
| irq_lvl_sel_i | input | 10 | Level-select per vector (1 = raised level) |
| cpu_rdy_i | input | 1 | Core can take an interrupt in this cycle |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge of an accepted vector |
| vec_o | output | 8 | Registered vector address of the last accepted request |

## Verification
The properties assume that `reti_i` is raised only by a handler that is really running. They also assume that the request, enable, select, ready and return inputs are synchronous and settled before each rising edge.

The bench changes all inputs on the falling edge. Its directed sequences issue one return per acknowledged handler. The random phase does send returns with nothing in service, which is legal (R9 leaves the state untouched), so that the empty-stack case is covered too. Requests are not cleared automatically in the random phase. This exercises the hold-off rule against persistent requests, and the reference model applies the same rule.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    // Priority levels; the numeric order is the arbitration order.
    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2,
        LV_TOP  = 2'd3
    } lvl_e;

    localparam int unsigned NUM_LVL = 3;

endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_nest_pkg::*;
#(
    parameter int unsigned NVEC = 10,
    parameter int unsigned NTOP = 2
) (
    input  logic [NVEC-1:0]      sel_i,
    output logic [NVEC-1:0][1:0] lvl_o
);

    // Vectors below NTOP can be raised to the top level, the rest only to the middle level.
    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        if (g < NTOP) begin : g_top
            assign lvl_o[g] = sel_i[g] ? LV_TOP : LV_LOW;
        end else begin : g_std
            assign lvl_o[g] = sel_i[g] ? LV_HIGH : LV_LOW;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_nest_pkg::*;
#(
    parameter int unsigned NVEC = 10,
    localparam int unsigned IW  = (NVEC > 1) ? $clog2(NVEC) : 1
) (
    input  logic [NVEC-1:0]      req_i,
    input  logic [NVEC-1:0]      en_i,
    input  logic [NVEC-1:0][1:0] lvl_i,
    input  logic [1:0]           cur_lvl_i,
    output logic                 found_o,
    output logic [IW-1:0]        idx_o,
    output logic [1:0]           win_lvl_o
);

    logic [NVEC-1:0] elig;

    // A vector competes only when requested, enabled and strictly above the running level.
    always_comb begin
        for (int i = 0; i < NVEC; i++) begin
            elig[i] = req_i[i] && en_i[i] && (lvl_i[i] > cur_lvl_i);
        end
    end

    // Strict comparison keeps the lowest index among equal levels.
    always_comb begin
        found_o   = 1'b0;
        idx_o     = '0;
        win_lvl_o = LV_NONE;
        for (int i = 0; i < NVEC; i++) begin
            if (elig[i] && (lvl_i[i] > win_lvl_o)) begin
                found_o   = 1'b1;
                idx_o     = IW'(i);
                win_lvl_o = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_isr_stack.sv
module irq_isr_stack
    import irq_nest_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [1:0] push_lvl_i,
    input  logic       pop_i,
    output logic [1:0] cur_lvl_o
);

    typedef struct packed {
        logic [NUM_LVL-1:0] act;
    } stk_t;

    stk_t stk_d, stk_q;

    // Innermost level = highest set flag.
    always_comb begin
        cur_lvl_o = LV_NONE;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (stk_q.act[i]) cur_lvl_o = 2'(i + 1);
        end
    end

    always_comb begin
        stk_d = stk_q;
        if (pop_i) begin
            for (int i = 0; i < NUM_LVL; i++) begin
                if (int'(cur_lvl_o) == i + 1) stk_d.act[i] = 1'b0;
            end
        end else if (push_i) begin
            for (int i = 0; i < NUM_LVL; i++) begin
                if (int'(push_lvl_i) == i + 1) stk_d.act[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned NVEC     = 10,
    parameter int unsigned NTOP     = 2,
    parameter int unsigned VW       = 8,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] irq_req_i,
    input  logic [NVEC-1:0] irq_en_i,
    input  logic [NVEC-1:0] irq_lvl_sel_i,
    input  logic            cpu_rdy_i,
    input  logic            reti_i,
    output logic            ack_o,
    output logic [VW-1:0]   vec_o
);

    localparam int unsigned IW = (NVEC > 1) ? $clog2(NVEC) : 1;

    typedef struct packed {
        logic          ack;
        logic [VW-1:0] vec;
    } out_t;

    out_t out_d, out_q;

    logic [NVEC-1:0][1:0] lvl;
    logic [1:0]           cur_lvl;
    logic                 found;
    logic [IW-1:0]        win_idx;
    logic [1:0]           win_lvl;
    logic                 accept;

    irq_level_map #(.NVEC(NVEC), .NTOP(NTOP)) u_map (
        .sel_i (irq_lvl_sel_i),
        .lvl_o (lvl)
    );

    irq_prio_pick #(.NVEC(NVEC)) u_pick (
        .req_i     (irq_req_i),
        .en_i      (irq_en_i),
        .lvl_i     (lvl),
        .cur_lvl_i (cur_lvl),
        .found_o   (found),
        .idx_o     (win_idx),
        .win_lvl_o (win_lvl)
    );

    // Return takes precedence; no acceptance in the cycle right after an acknowledge.
    assign accept = found && cpu_rdy_i && !reti_i && !out_q.ack;

    irq_isr_stack u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (accept),
        .push_lvl_i (win_lvl),
        .pop_i      (reti_i),
        .cur_lvl_o  (cur_lvl)
    );

    always_comb begin
        out_d     = out_q;
        out_d.ack = accept;
        if (accept) out_d.vec = VW'(VEC_BASE + VEC_STEP * int'(win_idx));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ack_o = out_q.ack;
    assign vec_o = out_q.vec;

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
    parameter int unsigned NVEC     = 10,
    parameter int unsigned VW       = 8,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NVEC-1:0] irq_req_i,
    input logic [NVEC-1:0] irq_en_i,
    input logic            cpu_rdy_i,
    input logic            reti_i,
    input logic            ack_o,
    input logic [VW-1:0]   vec_o,
    input logic [1:0]      cur_lvl
);

    localparam int unsigned VMAX = VEC_BASE + VEC_STEP * (NVEC - 1);

    logic [NVEC-1:0] req_en_q;
    int              widx;

    always_ff @(posedge clk) begin
        if (!rst_n) req_en_q <= '0;
        else        req_en_q <= irq_req_i & irq_en_i;
    end

    always_comb widx = (int'(vec_o) - int'(VEC_BASE)) / int'(VEC_STEP);

    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    p_ack_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(cpu_rdy_i) && !$past(reti_i)));

    p_vec_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ((int'(vec_o) >= int'(VEC_BASE)) && (int'(vec_o) <= int'(VMAX))
                   && (((int'(vec_o) - int'(VEC_BASE)) % int'(VEC_STEP)) == 0)));

    p_ack_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && widx >= 0 && widx < int'(NVEC)) |-> req_en_q[widx]);

    p_nest_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (cur_lvl > $past(cur_lvl)));

    p_top_only_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && int'(vec_o) > int'(VEC_BASE + VEC_STEP)) |-> (cur_lvl != 2'd3));

    p_pop_lowers_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && cur_lvl != 2'd0) |=> (cur_lvl < $past(cur_lvl)));

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && cur_lvl == 2'd0) |=> (cur_lvl == 2'd0 && !ack_o));

    p_vec_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_o |-> $stable(vec_o));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(
    .NVEC(NVEC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .cpu_rdy_i (cpu_rdy_i),
    .reti_i    (reti_i),
    .ack_o     (ack_o),
    .vec_o     (vec_o),
    .cur_lvl   (cur_lvl)
);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] req = '0;
    logic [9:0] en = '0;
    logic [9:0] sel = '0;
    logic       rdy = 1'b0;
    logic       reti = 1'b0;
    logic       ack;
    logic [7:0] vec;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string phase = "R1";

    // reference model state
    int       stk[$];
    bit       m_ack = 1'b0;
    bit [7:0] m_vec = 8'h00;

    always #4 clk = ~clk;

    irq_nest_ctrl u_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .irq_en_i(en),
        .irq_lvl_sel_i(sel), .cpu_rdy_i(rdy), .reti_i(reti),
        .ack_o(ack), .vec_o(vec)
    );

    function automatic int lvl_of(int i);
        if (i < 2) return sel[i] ? 3 : 1;
        return sel[i] ? 2 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            stk.delete();
            m_ack = 1'b0;
            m_vec = 8'h00;
        end else begin
            bit prev_ack;
            int cur;
            int best;
            int bi;
            prev_ack = m_ack;
            m_ack = 1'b0;
            cur = (stk.size() > 0) ? stk[$] : 0;
            if (reti) begin
                if (stk.size() > 0) void'(stk.pop_back());
            end else if (rdy && !prev_ack) begin
                best = 0;
                bi = -1;
                for (int i = 0; i < 10; i++) begin
                    if (req[i] && en[i] && lvl_of(i) > cur && lvl_of(i) > best) begin
                        best = lvl_of(i);
                        bi = i;
                    end
                end
                if (bi >= 0) begin
                    stk.push_back(best);
                    m_ack = 1'b1;
                    m_vec = 8'(3 + 8 * bi);
                end
            end
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check({phase, " ack"}, {7'd0, ack}, {7'd0, m_ack});
            check({phase, " vec"}, vec, m_vec);
        end
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        req = '0;
        reti = 1'b1;
        step(4);
        reti = 1'b0;
        step(1);
    endtask

    initial begin
        step(3);
        check("R1 ack in reset", {7'd0, ack}, 8'd0);
        check("R1 vec in reset", vec, 8'h00);
        rst_n = 1'b1;
        step(1);
        check("R1 ack after reset", {7'd0, ack}, 8'd0);
        en = '1;
        rdy = 1'b1;
        req[9] = 1'b1;
        step(1);
        check("R1 first low accept", vec, 8'h4B);
        drain();

        phase = "R2";
        for (int k = 0; k < 10; k++) begin
            req = 10'(1) << k;
            step(1);
            check("R2 vector address", vec, 8'(3 + 8 * k));
            drain();
        end

        phase = "R3";
        sel = 10'b0000000101;
        req = 10'b0000000101;
        step(1);
        check("R3 top beats middle", vec, 8'h03);
        drain();
        sel = 10'b0000000110;
        req = 10'b0000000110;
        step(1);
        check("R3 vector2 top", vec, 8'h0B);
        drain();
        sel = 10'b0000001000;
        req = 10'b0000001001;
        step(1);
        check("R3 middle beats low vector1", vec, 8'h1B);
        drain();

        phase = "R4";
        sel = '0;
        en = 10'b1111111110;
        req = 10'b0000000001;
        step(3);
        check("R4 disabled ignored", {7'd0, ack}, 8'd0);
        en = '1;
        req = '0;
        drain();

        phase = "R5";
        sel = 10'b0000010000;
        req = 10'b0000010011;
        step(1);
        check("R5 higher level wins", vec, 8'h23);
        drain();

        phase = "R6";
        sel = '0;
        req = 10'b0101010000;
        step(1);
        check("R6 lowest address wins", vec, 8'h23);
        drain();

        phase = "R7";
        sel = 10'b0000101000;
        req = 10'b0000001000;
        step(1);
        check("R7 middle accepted", vec, 8'h1B);
        req = 10'b0000100001;
        step(4);
        check("R7 equal and lower held", {7'd0, ack}, 8'd0);
        check("R7 vec kept", vec, 8'h1B);
        reti = 1'b1;
        step(1);
        reti = 1'b0;
        step(1);
        check("R7 accepted after return", vec, 8'h2B);
        drain();

        phase = "R8";
        sel = 10'b0000010001;
        req = 10'b0000000100;
        step(1);
        check("R8 low entry", vec, 8'h13);
        req = 10'b0000010000;
        step(2);
        check("R8 middle preempts", vec, 8'h23);
        req = 10'b0000000001;
        step(2);
        check("R8 top preempts", vec, 8'h03);
        drain();

        phase = "R9";
        req = '0;
        reti = 1'b1;
        step(2);
        reti = 1'b0;
        sel = '0;
        req = 10'b1000000000;
        step(1);
        check("R9 empty return harmless", vec, 8'h4B);
        drain();

        phase = "R10";
        rdy = 1'b0;
        req = 10'b0000000010;
        step(3);
        check("R10 no ack without ready", {7'd0, ack}, 8'd0);
        rdy = 1'b1;
        reti = 1'b1;
        step(1);
        check("R10 no ack with return", {7'd0, ack}, 8'd0);
        reti = 1'b0;
        step(1);
        check("R10 ack after ready", vec, 8'h0B);
        sel = 10'b0000000001;
        req = 10'b0000000011;
        step(1);
        check("R10 no back-to-back ack", {7'd0, ack}, 8'd0);
        step(1);
        check("R10 next ack", vec, 8'h03);

        phase = "R11";
        req = '0;
        step(5);
        check("R11 vec holds", vec, 8'h03);
        drain();

        phase = "R5 random";
        for (int c = 0; c < 4000; c++) begin
            req = 10'($urandom) & 10'($urandom) & 10'($urandom);
            en = 10'($urandom) | 10'($urandom);
            sel = 10'($urandom);
            rdy = ($urandom % 4) != 0;
            reti = ($urandom % 5) == 0;
            step(1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule